// File: doc/BRIEF.md
# Shared-Register Serial Port for a Multi-Channel Converter

This block is the converter-side end of a synchronous serial link to a host processor. A single 16-bit shift register carries words in both directions. The port is always the master. Each sample event loads the register with an outgoing word, and the port then starts a frame on its own: it raises a frame-sync strobe and shifts the word out most significant bit first. The host shifts its word in during the same serial periods. A host word is framed by an input sync and is decoded only once all 16 bits are in. A decoded control word writes one of eight 8-bit configuration registers, or asks for one of them to be returned in the next outgoing frame.

Register 0 picks the operating mode:
- **Program mode**: control words are accepted, and idle frames carry zero.
- **Data mode**: host input is ignored, and samples go out at full width.
- **Mixed mode**: control words are accepted, and samples go out shifted right so that the top bit is a zero flag, which leaves 15 bits of resolution.

Register 1 sets two clock dividers. The first divides the input clock into the internal master rate. The second divides that rate into the serial bit rate. The port reports each serial bit instant on `bit_tick`.

Top module: `codec_sport`

## Requirements
- R1: A frame is 16 bits. One bit is emitted on `sdo` at each serial tick, MSB first. `sdofs` is high for the serial period of the first bit only and low for the other 15.
- R2: A frame is sent only after a sample event (`smp_evt`). The event loads the shared register, and the frame begins at the next serial tick.
- R3: Program mode is any value of register 0 with bit 0 = 0, including bits[1:0] = 10. In this mode a received word with bit 15 = 1 and bit 14 = 0 writes bits 7:0 into the register addressed by bits 13:11. A received word with bit 15 = 0 is ignored.
- R4: A received word with bit 15 = 1 and bit 14 = 1 is a read request. The next sample-event frame carries {1, 1, address[2:0], 000, register[7:0]} in place of its normal content.
- R5: In program mode, a frame with no read reply pending carries 0x0000.
- R6: Data mode is register 0 bits[1:0] = 01. In this mode every received word is ignored, no read reply is sent, and each frame carries the sample word unchanged.
- R7: Mixed mode is register 0 bits[1:0] = 11. Frames carry {0, sample[15:1]}, and received words are handled as in program mode.
- R8: Register 1 bits 2:0 select the master divider: codes 0 to 4 give ÷1 to ÷5, and codes 5 to 7 give ÷1. Register 1 bits 4:3 select the serial divider: ÷1, ÷2, ÷4 or ÷8. `bit_tick` recurs every (master × serial) clock cycles.
- R9: A synchronous reset clears all eight registers. This selects program mode and ÷1/÷1 dividers. It also clears any pending reply, and `sdo`, `sdofs` and `bit_tick` are low while reset is held.
- R10: A host word starts when `sdifs` is sampled high at a tick while the port is idle, or at the tick where the port starts its own frame. The word is acted on only after its 16th bit. A sample event that arrives earlier discards the partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External master clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_evt | input | 1 | One-cycle sample event strobe |
| smp_word | input | 16 | Newest converter word, taken at `smp_evt` |
| sdi | input | 1 | Serial data from host, sampled at tick edges |
| sdifs | input | 1 | Input frame sync from host, sampled at tick edges |
| bit_tick | output | 1 | High in the cycle before each serial bit edge |
| sdo | output | 1 | Serial data to host |
| sdofs | output | 1 | Output frame sync, high during the first bit |

## Verification
`bit_tick` is registered. The clock edge that follows a cycle with `bit_tick` high samples `sdi` and `sdifs` and updates `sdo` and `sdofs`. The bench therefore drives host bits at falling edges where `bit_tick` is high. It reads each output bit at the falling edge after such a tick.

A sample event loaded at one edge starts its frame at the next tick edge. The monitor assembles 16 bits from the `sdofs` bit onward and compares them with the queued prediction.

A control word takes effect in the cycle after its 16th bit. The bench therefore leaves idle ticks before it relies on the change. Divider changes are measured as the number of cycles between two consecutive ticks.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic [1:0] {
    MODE_PROG  = 2'd0,
    MODE_DATA  = 2'd1,
    MODE_MIXED = 2'd2
  } port_mode_t;

  // bit 0 clear -> program; bit 0 set -> data unless bit 1 also set
  function automatic port_mode_t mode_of(input logic [1:0] sel);
    if (!sel[0])
      return MODE_PROG;
    else if (sel[1])
      return MODE_MIXED;
    else
      return MODE_DATA;
  endfunction

endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int MDIV_MAX     = 5,
  parameter int SDIV_LOG_MAX = 3,
  localparam int MCNT_W = $clog2(MDIV_MAX + 1),
  localparam int SSEL_W = $clog2(SDIV_LOG_MAX + 1),
  localparam int SCNT_W = (SDIV_LOG_MAX < 1) ? 1 : SDIV_LOG_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MCNT_W-1:0] mcode,
  input  logic [SSEL_W-1:0] scode,
  output logic              tick
);

  logic [MCNT_W-1:0] dm_cnt;
  logic [SCNT_W-1:0] sc_cnt;
  logic [MCNT_W-1:0] mdiv_m1;
  logic [SCNT_W:0]   sdiv_n;
  logic [SCNT_W-1:0] sdiv_m1;
  logic              dm_wrap, sc_wrap;

  always_comb begin
    mdiv_m1 = (mcode < MCNT_W'(MDIV_MAX)) ? mcode : '0;
    sdiv_n  = (SCNT_W + 1)'(1) << scode;
    sdiv_m1 = SCNT_W'(sdiv_n - 1'b1);
    // >= keeps the counters bounded when a smaller ratio is written mid-count
    dm_wrap = (dm_cnt >= mdiv_m1);
    sc_wrap = (sc_cnt >= sdiv_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_cnt <= '0;
      sc_cnt <= '0;
      tick   <= 1'b0;
    end else begin
      tick <= dm_wrap && sc_wrap;
      if (dm_wrap) begin
        dm_cnt <= '0;
        sc_cnt <= sc_wrap ? '0 : sc_cnt + 1'b1;
      end else begin
        dm_cnt <= dm_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sport_regbank.sv
module sport_regbank #(
  parameter int NREG  = 8,
  parameter int REG_W = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] cfg_a,
  output logic [REG_W-1:0] cfg_b
);

  logic [REG_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) regs[wr_addr] <= wr_data;
      if (rd_en) rd_data <= regs[rd_addr];
    end
  end

  assign cfg_a = regs[0];
  assign cfg_b = regs[1];

endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
  parameter int WORD_W = 16,
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              sdi,
  input  logic              sdifs,
  output logic              sdo,
  output logic              sdofs,
  output logic              rx_done,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] sreg;
  logic [CW-1:0]     cnt;
  logic              active, tx_pend, rx_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      tx_pend <= 1'b0;
      rx_flag <= 1'b0;
      sdo     <= 1'b0;
      sdofs   <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (load) begin
        // sample event owns the shared register; any partial word is lost
        sreg    <= load_word;
        tx_pend <= 1'b1;
        active  <= 1'b0;
        rx_flag <= 1'b0;
        cnt     <= '0;
        sdo     <= 1'b0;
        sdofs   <= 1'b0;
      end else if (tick) begin
        if (active || tx_pend || sdifs) begin
          sdo  <= sreg[WORD_W-1];
          sreg <= {sreg[WORD_W-2:0], sdi};
          if (!active) begin
            active  <= 1'b1;
            cnt     <= CW'(1);
            sdofs   <= tx_pend;
            tx_pend <= 1'b0;
            rx_flag <= sdifs;
          end else begin
            sdofs <= 1'b0;
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(WORD_W - 1)) begin
              active  <= 1'b0;
              rx_done <= rx_flag;
            end
          end
        end else begin
          sdo   <= 1'b0;
          sdofs <= 1'b0;
        end
      end
    end
  end

  assign rx_word = sreg;

endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import sport_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int NREG         = 8,
  parameter int REG_W        = 8,
  parameter int MDIV_MAX     = 5,
  parameter int SDIV_LOG_MAX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_evt,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              sdi,
  input  logic              sdifs,
  output logic              bit_tick,
  output logic              sdo,
  output logic              sdofs
);

  localparam int AW        = $clog2(NREG);
  localparam int MCNT_W    = $clog2(MDIV_MAX + 1);
  localparam int SSEL_W    = $clog2(SDIV_LOG_MAX + 1);
  localparam int REPLY_PAD = WORD_W - 2 - AW - REG_W;
  localparam int ADDR_MSB  = WORD_W - 3;

  logic [REG_W-1:0]  cfg_a, cfg_b, rd_data;
  logic [WORD_W-1:0] rx_word, load_word;
  logic              rx_done, is_ctl, wr_en, rd_en;
  logic              reply_pend;
  logic [AW-1:0]     reply_addr;
  port_mode_t        mode;

  assign mode   = mode_of(cfg_a[1:0]);
  assign is_ctl = rx_done && (mode != MODE_DATA) && rx_word[WORD_W-1];
  assign wr_en  = is_ctl && !rx_word[WORD_W-2];
  assign rd_en  = is_ctl &&  rx_word[WORD_W-2];

  sport_clkgen #(
    .MDIV_MAX     (MDIV_MAX),
    .SDIV_LOG_MAX (SDIV_LOG_MAX)
  ) clkgen_i (
    .clk   (clk),
    .rst   (rst),
    .mcode (cfg_b[MCNT_W-1:0]),
    .scode (cfg_b[MCNT_W+SSEL_W-1:MCNT_W]),
    .tick  (bit_tick)
  );

  sport_regbank #(
    .NREG  (NREG),
    .REG_W (REG_W)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (rx_word[ADDR_MSB -: AW]),
    .wr_data (rx_word[REG_W-1:0]),
    .rd_en   (rd_en),
    .rd_addr (rx_word[ADDR_MSB -: AW]),
    .rd_data (rd_data),
    .cfg_a   (cfg_a),
    .cfg_b   (cfg_b)
  );

  // a read answer waits for the next self-initiated frame
  always_ff @(posedge clk) begin
    if (rst) begin
      reply_pend <= 1'b0;
      reply_addr <= '0;
    end else if (smp_evt) begin
      reply_pend <= 1'b0;
    end else if (rd_en) begin
      reply_pend <= 1'b1;
      reply_addr <= rx_word[ADDR_MSB -: AW];
    end
  end

  always_comb begin
    if (reply_pend && mode != MODE_DATA)
      load_word = {2'b11, reply_addr, {REPLY_PAD{1'b0}}, rd_data};
    else begin
      unique case (mode)
        MODE_DATA:  load_word = smp_word;
        MODE_MIXED: load_word = {1'b0, smp_word[WORD_W-1:1]};
        default:    load_word = '0;
      endcase
    end
  end

  sport_shifter #(
    .WORD_W (WORD_W)
  ) shift_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .load      (smp_evt),
    .load_word (load_word),
    .sdi       (sdi),
    .sdifs     (sdifs),
    .sdo       (sdo),
    .sdofs     (sdofs),
    .rx_done   (rx_done),
    .rx_word   (rx_word)
  );

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_a[REG_W-1:2], cfg_b[REG_W-1:MCNT_W+SSEL_W],
                             rx_word[ADDR_MSB-AW -: REPLY_PAD]};

endmodule

// File: rtl/codec_sport_chk.sv
module codec_sport_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_evt,
  input logic       bit_tick,
  input logic       sdo,
  input logic       sdofs,
  input logic [1:0] mode_bits
);

  AST_FS_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (sdofs && bit_tick && !smp_evt) |=> !sdofs); // R1

  AST_OUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_tick) && !$past(smp_evt)) |-> ($stable(sdo) && $stable(sdofs))); // R1

  AST_DATA_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (mode_bits == 2'b01) |=> (mode_bits == 2'b01)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sdo && !sdofs && !bit_tick)); // R9

endmodule

bind codec_sport codec_sport_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .smp_evt   (smp_evt),
  .bit_tick  (bit_tick),
  .sdo       (sdo),
  .sdofs     (sdofs),
  .mode_bits (cfg_a[1:0])
);

// File: tb/codec_sport_tb_top.sv
`timescale 1ns/1ps
module codec_sport_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_evt = 1'b0;
  logic [15:0] smp_word = '0;
  logic        sdi = 1'b0;
  logic        sdifs = 1'b0;
  logic        bit_tick, sdo, sdofs;

  always #10 clk = ~clk;

  codec_sport dut_i (
    .clk      (clk),
    .rst      (rst),
    .smp_evt  (smp_evt),
    .smp_word (smp_word),
    .sdi      (sdi),
    .sdifs    (sdifs),
    .bit_tick (bit_tick),
    .sdo      (sdo),
    .sdofs    (sdofs)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] mdl_reg [8];
  bit         mdl_pend;
  logic [2:0] mdl_addr;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mdl_reg[i] = '0;
    mdl_pend = 1'b0;
    mdl_addr = '0;
  endtask

  function automatic logic [15:0] predict(input logic [15:0] s);
    logic [1:0]  m;
    logic [15:0] r;
    m = mdl_reg[0][1:0];
    if (mdl_pend && m != 2'b01)
      r = {2'b11, mdl_addr, 3'b000, mdl_reg[mdl_addr]};
    else if (!m[0])
      r = 16'h0000;
    else if (m[1])
      r = {1'b0, s[15:1]};
    else
      r = s;
    mdl_pend = 1'b0;
    return r;
  endfunction

  task automatic model_rx(input logic [15:0] w);
    if (mdl_reg[0][1:0] != 2'b01 && w[15]) begin
      if (w[14]) begin
        mdl_pend = 1'b1;
        mdl_addr = w[13:11];
      end else begin
        mdl_reg[w[13:11]] = w[7:0];
      end
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
  endtask

  // driver: sample event, predicted frame queued, optional host word alongside
  task automatic frame(input logic [15:0] s, input logic [15:0] ctl,
                       input bit send, input string tag);
    exp_q.push_back(predict(s));
    tag_q.push_back(tag);
    @(negedge clk);
    smp_evt  = 1'b1;
    smp_word = s;
    @(negedge clk);
    smp_evt = 1'b0;
    while (!bit_tick) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      sdifs = send && (i == 15);
      sdi   = send ? ctl[i] : 1'b0;
      wait_tick();
    end
    sdifs = 1'b0;
    sdi   = 1'b0;
    if (send) model_rx(ctl);
    repeat (4) wait_tick();
  endtask

  task automatic host_word(input logic [15:0] w, input int nbits);
    wait_tick();
    for (int i = 15; i > 15 - nbits; i--) begin
      sdifs = (i == 15);
      sdi   = w[i];
      wait_tick();
    end
    sdifs = 1'b0;
    sdi   = 1'b0;
    if (nbits == 16) begin
      model_rx(w);
      repeat (4) wait_tick();
    end
  endtask

  task automatic measure(input int expv, input string req);
    int cnt;
    wait_tick();
    cnt = 0;
    @(negedge clk);
    cnt = 1;
    while (!bit_tick) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == expv, req, "tick period", cnt, expv);
  endtask

  // monitor: assemble frames from the sdofs bit and compare to the queue
  initial begin
    bit          last_tick = 1'b0;
    bit          in_fr = 1'b0;
    bit          fs_extra = 1'b0;
    int          n = 0;
    logic [15:0] cap = '0;
    logic [15:0] e;
    string       t;
    forever begin
      @(negedge clk);
      if (rst) begin
        last_tick = 1'b0;
        in_fr     = 1'b0;
      end else begin
        if (last_tick) begin
          if (!in_fr && sdofs) begin
            in_fr    = 1'b1;
            fs_extra = 1'b0;
            cap      = {15'b0, sdo};
            n        = 1;
          end else if (in_fr) begin
            if (sdofs) fs_extra = 1'b1;
            cap = {cap[14:0], sdo};
            n++;
          end
          if (in_fr && n == 16) begin
            in_fr = 1'b0;
            check(!fs_extra, "R1", "sync beyond first bit", 1, 0);
            if (exp_q.size() == 0) begin
              check(1'b0, "R2", "unexpected frame", cap, 0);
            end else begin
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              check(cap == e, t, "frame word", cap, e);
            end
          end
        end
        last_tick = bit_tick;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    check(!sdo && !sdofs && !bit_tick, "R9", "outputs in reset",
          {sdo, sdofs, bit_tick}, 0);
    rst = 1'b0;
    measure(1, "R9");

    // program mode: write, read, ignored non-control word
    frame(16'h1234, 16'h98A5, 1, "R5");
    frame(16'h1111, 16'hD800, 1, "R5");
    frame(16'h2222, 16'h18FF, 1, "R4");
    frame(16'h3333, 16'hD800, 1, "R3");
    frame(16'h0000, 16'h0000, 0, "R3");
    // bits[1:0]=10 stays program mode
    frame(16'h4444, 16'h8002, 1, "R3");
    frame(16'h5555, 16'h0000, 0, "R3");

    // dividers
    frame(16'h0000, 16'h880A, 1, "R8");
    measure(6, "R8");
    frame(16'h6666, 16'hC800, 1, "R8");
    frame(16'h0000, 16'h0000, 0, "R4");
    frame(16'h0000, 16'h881C, 1, "R8");
    measure(40, "R8");
    frame(16'h0000, 16'h880F, 1, "R8");
    measure(2, "R8");
    frame(16'h0000, 16'h8800, 1, "R8");
    measure(1, "R8");

    // mixed mode
    frame(16'h7777, 16'h8003, 1, "R5");
    frame(16'hBEEF, 16'hC000, 1, "R7");
    frame(16'h1357, 16'h7FFF, 1, "R4");
    frame(16'hFFFF, 16'h0000, 0, "R7");

    // data mode
    frame(16'h8001, 16'h8001, 1, "R7");
    frame(16'h8001, 16'h8000, 1, "R6");
    frame(16'h1234, 16'hC000, 1, "R6");
    frame(16'hABCD, 16'h0000, 0, "R6");

    // reset returns defaults
    @(negedge clk);
    rst = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    check(!sdo && !sdofs && !bit_tick, "R9", "outputs in second reset",
          {sdo, sdofs, bit_tick}, 0);
    rst = 1'b0;
    measure(1, "R9");
    frame(16'h4321, 16'hD800, 1, "R9");
    frame(16'h0000, 16'h0000, 0, "R9");

    // host-only word, then a word cut short by a sample event
    host_word(16'h9877, 16);
    frame(16'h0000, 16'hD800, 1, "R10");
    frame(16'h0000, 16'h0000, 0, "R10");
    host_word(16'h98EE, 8);
    frame(16'h0000, 16'hD800, 1, "R10");
    frame(16'h0000, 16'h0000, 0, "R10");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2", "frames outstanding", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule